// File: doc/BRIEF.md
# Group Address Hash Filter

This block decides whether a received group (multicast) destination address should be accepted. The six destination address bytes arrive as a byte stream, at most one byte per clock, in the order they appear on the wire. While they arrive, the block folds each byte into a running Ethernet CRC-32. The bits of each byte enter the CRC least significant bit first. Eight bits of the result form an index into a 256-entry, one-bit-per-entry acceptance table. Once the sixth byte has been taken, the block reports the index and a match verdict.

The acceptance table is held in eight 32-bit words. Software fills them through a plain register port: a write strobe, a word select and the write data, plus a registered read-back of the selected word. A lookup can only match when the table bit it lands on is set. It can also only match when the address is a group address, meaning the first byte has its least significant bit set. Any other address yields a no-match.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all eight table words read as 0x00000000, lookup_done and lookup_match are low, and a group address sent straight after reset completes with lookup_match low.
- R2: A write with cfg_we high stores cfg_wdata into the word selected by cfg_addr (0 to 7). cfg_rdata presents the word selected by cfg_addr one clock after that select is sampled.
- R3: lookup_idx equals the bit-reverse of the low 8 bits of the reflected CRC-32, with no final inversion. That CRC uses polynomial 0xEDB88320, is preset to 0xFFFFFFFF for each address, and takes bytes in arrival order with each byte's bit 0 first. Equivalently, lookup_idx is the top 8 bits of the bit-reversed CRC.
- R4: Table entry k (0 to 255) is bit 31 - (k mod 32) of word k / 32. Entry 0 is therefore bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R5: A byte is taken on every clock edge where addr_valid is high, and idle cycles between bytes do not advance the count. lookup_done is high for exactly one cycle, on the cycle after the sixth byte is taken.
- R6: An address whose first byte has bit 0 clear completes with lookup_done high and lookup_match low, whatever the table holds.
- R7: For a group address, lookup_match is high with lookup_done exactly when the table entry at lookup_idx is set. lookup_match is never high without lookup_done.
- R8: A new address may start on the cycle right after the sixth byte of the previous one, and its CRC starts again from the preset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table word write strobe |
| cfg_addr | input | 3 | Table word select, for both write and read |
| cfg_wdata | input | 32 | Table word write data |
| cfg_rdata | output | 32 | Registered read-back of the selected word |
| addr_valid | input | 1 | A destination address byte is present |
| addr_byte | input | 8 | Destination address byte, first wire byte first |
| lookup_done | output | 1 | One-cycle strobe when a lookup result is ready |
| lookup_match | output | 1 | The address is accepted, valid with lookup_done |
| lookup_idx | output | 8 | Hash index of the last completed address |

## Verification
A wrong byte count or a CRC state not restored to its preset shows up as a lookup_done strobe on the wrong cycle. It can also show up as a wrong lookup_idx, first seen on the very next completed address, so back-to-back and gapped streams are compared against an independently computed reflected CRC. A fault in the word or bit mapping of the table cannot be seen through the index alone. It shows only as a wrong lookup_match, so the table is filled with every bit set except the one addressed entry, and then with only that entry set, at the entries 0 and 255 and at arbitrary hash values. A stale group flag shows as a match on a unicast address in the cycle after its sixth byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int          CRC_W      = 32;
  localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
  localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

  // Fold one byte into a left-shifting CRC, data bit 0 first.
  // The register then holds the bit-reverse of the reflected CRC.
  function automatic logic [CRC_W-1:0] crc_byte_step(input logic [CRC_W-1:0] c,
                                                      input logic [7:0]       d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             beat_last,
  output logic             beat_group,
  output logic [IDX_W-1:0] beat_idx
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nx;
  logic             grp_q;
  logic             first_beat;

  assign crc_nx     = crc_byte_step(crc_q, in_byte);
  assign first_beat = (cnt_q == '0);
  assign beat_last  = in_valid && (cnt_q == LAST_CNT);
  assign beat_group = first_beat ? in_byte[0] : grp_q;
  assign beat_idx   = crc_nx[CRC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      crc_q <= CRC_PRESET;
      grp_q <= 1'b0;
    end else if (in_valid) begin
      if (first_beat) grp_q <= in_byte[0];
      if (beat_last) begin
        cnt_q <= '0;
        crc_q <= CRC_PRESET;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        crc_q <= crc_nx;
      end
    end
  end

  // R5: the byte count never leaves its range
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_CNT);

  // R5: idle cycles leave the count and CRC untouched
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cnt_q) && $stable(crc_q)));

  // R8: a finished address leaves the CRC at its preset
  p_preset_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    beat_last |=> (crc_q == CRC_PRESET && cnt_q == '0));

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic [$clog2((1 << IDX_W) / WORD_W)-1:0]   wr_sel,
  input  logic [WORD_W-1:0]                          wr_data,
  input  logic [$clog2((1 << IDX_W) / WORD_W)-1:0]   rd_sel,
  output logic [WORD_W-1:0]                          rd_data,
  input  logic [IDX_W-1:0]                           lk_idx,
  output logic                                       lk_hit
);
  localparam int NUM_WORDS = (1 << IDX_W) / WORD_W;
  localparam int SEL_W     = $clog2(NUM_WORDS);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [WORD_W-1:0] lk_word;
  logic [SEL_W-1:0]  lk_sel;
  logic [BIT_W-1:0]  lk_pos;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                   mem_q[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))     mem_q[g] <= wr_data;
    end

    // R2: a write lands in the selected word
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(g)) |=> (mem_q[g] == $past(wr_data)));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem_q[rd_sel];
  end

  // Upper index bits pick the word, lower bits count down from the MSB.
  assign lk_sel  = lk_idx[IDX_W-1 -: SEL_W];
  assign lk_pos  = TOP_BIT - lk_idx[BIT_W-1:0];
  assign lk_word = mem_q[lk_sel];
  assign lk_hit  = lk_word[lk_pos];

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 8,
  parameter int WORD_W     = 32
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       cfg_we,
  input  logic [$clog2((1 << IDX_W) / WORD_W)-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]                          cfg_wdata,
  output logic [WORD_W-1:0]                          cfg_rdata,
  input  logic                                       addr_valid,
  input  logic [7:0]                                 addr_byte,
  output logic                                       lookup_done,
  output logic                                       lookup_match,
  output logic [IDX_W-1:0]                           lookup_idx
);
  logic             beat_last;
  logic             beat_group;
  logic [IDX_W-1:0] beat_idx;
  logic             tbl_hit;

  mhf_crc_engine #(
    .ADDR_BYTES (ADDR_BYTES),
    .IDX_W      (IDX_W)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (addr_valid),
    .in_byte    (addr_byte),
    .beat_last  (beat_last),
    .beat_group (beat_group),
    .beat_idx   (beat_idx)
  );

  mhf_hash_table #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_sel  (cfg_addr),
    .rd_data (cfg_rdata),
    .lk_idx  (beat_idx),
    .lk_hit  (tbl_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lookup_done  <= 1'b0;
      lookup_match <= 1'b0;
      lookup_idx   <= '0;
    end else begin
      lookup_done  <= beat_last;
      lookup_match <= beat_last && beat_group && tbl_hit;
      if (beat_last) lookup_idx <= beat_idx;
    end
  end

  // R5: the result follows the sixth byte by one cycle
  p_done_follows_last_r5: assert property (@(posedge clk) disable iff (rst)
    beat_last |=> lookup_done);

  // R5: the done strobe lasts a single cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    lookup_done |=> !lookup_done);

  // R6: individual addresses never match
  p_unicast_rejected_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !beat_group) |=> !lookup_match);

  // R7: a match is only reported together with done
  p_match_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
    lookup_match |-> lookup_done);

endmodule

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        addr_valid = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        lookup_done;
  logic        lookup_match;
  logic [7:0]  lookup_idx;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow [8];

  always #5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .lookup_done(lookup_done),
    .lookup_match(lookup_match), .lookup_idx(lookup_idx)
  );

  // {set entry, address}
  localparam logic [48:0] VEC [9] = '{
    {1'b1, 48'h01005E000001}, {1'b1, 48'h01005E7FFFFA},
    {1'b1, 48'h333300000001}, {1'b1, 48'hFFFFFFFFFFFF},
    {1'b0, 48'h010203040506}, {1'b1, 48'h0180C2000000},
    {1'b1, 48'h001122334455}, {1'b1, 48'h0300000000FF},
    {1'b1, 48'h020000000000}
  };

  // Reflected CRC-32, bit-reversed low byte gives the index.
  function automatic logic [7:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic [7:0]  r;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47 - 8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    for (int k = 0; k < 8; k++) r[7-k] = c[k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_word(input int w, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 3'(w);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic load_table;
    for (int w = 0; w < 8; w++) wr_word(w, shadow[w]);
  endtask

  task automatic fill_shadow(input logic [31:0] v);
    for (int w = 0; w < 8; w++) shadow[w] = v;
  endtask

  // Entered and left at a falling edge; optional idle cycle after each byte.
  task automatic send_addr(input logic [47:0] a, input bit gap, input string tag);
    for (int k = 0; k < 6; k++) begin
      addr_valid = 1'b1; addr_byte = a[47 - 8*k -: 8];
      @(negedge clk);
      if (gap && k < 5) begin
        addr_valid = 1'b0;
        chk({tag, " R5 no early done"}, 32'(lookup_done), 32'd0);
        @(negedge clk);
      end
    end
    addr_valid = 1'b0;
  endtask

  task automatic expect_result(input logic [47:0] a, input bit exp_m, input string tag);
    chk({tag, " R5 done"}, 32'(lookup_done), 32'd1);
    chk({tag, " R3 idx"}, 32'(lookup_idx), 32'(ref_idx(a)));
    chk({tag, " R7 match"}, 32'(lookup_match), 32'(exp_m));
  endtask

  task automatic set_entry_only(input logic [7:0] e, input bit invert);
    fill_shadow(invert ? 32'hFFFFFFFF : 32'h0);
    shadow[e[7:5]][31 - e[4:0]] = ~invert;
    load_table();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [47:0] a0, a255, b;
    bit f0, f255;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 done after reset", 32'(lookup_done), 32'd0);
    chk("R1 match after reset", 32'(lookup_match), 32'd0);
    for (int w = 0; w < 8; w++) begin
      rd_word(w, d);
      chk("R1 table word zero", d, 32'd0);
    end
    send_addr(48'h01005E000001, 1'b0, "R1");
    expect_result(48'h01005E000001, 1'b0, "R1 empty table");
    @(negedge clk);

    // R2: write and read back distinct words
    for (int w = 0; w < 8; w++) wr_word(w, 32'hA5000000 ^ (32'(w) * 32'h01010101));
    for (int w = 0; w < 8; w++) begin
      rd_word(w, d);
      chk("R2 readback", d, 32'hA5000000 ^ (32'(w) * 32'h01010101));
    end

    // Vector table: R3, R6, R7
    for (int v = 0; v < 9; v++) begin
      logic [7:0] e;
      bit exp_m;
      e = ref_idx(VEC[v][47:0]);
      set_entry_only(e, 1'b0);
      if (!VEC[v][48]) fill_shadow(32'h0);
      load_table();
      @(negedge clk);
      send_addr(VEC[v][47:0], 1'b0, "vec");
      exp_m = VEC[v][48] && VEC[v][40];
      expect_result(VEC[v][47:0], exp_m, "R3/R6/R7 vector");
      @(negedge clk);
      chk("R5 done single cycle", 32'(lookup_done), 32'd0);
      chk("R7 no match without done", 32'(lookup_match), 32'd0);
    end

    // R6: unicast with a full table
    fill_shadow(32'hFFFFFFFF);
    load_table();
    @(negedge clk);
    send_addr(48'h00A0C9112233, 1'b0, "R6");
    expect_result(48'h00A0C9112233, 1'b0, "R6 unicast full table");
    @(negedge clk);

    // R4: locate addresses hashing to entries 0 and 255
    f0 = 0; f255 = 0; a0 = '0; a255 = '0;
    for (int k = 0; k < 65536; k++) begin
      b = {32'h01005E00, 16'(k)};
      if (!f0 && ref_idx(b) == 8'd0)     begin a0 = b; f0 = 1; end
      if (!f255 && ref_idx(b) == 8'd255) begin a255 = b; f255 = 1; end
    end
    chk("R4 entry 0 address found", 32'(f0), 32'd1);
    chk("R4 entry 255 address found", 32'(f255), 32'd1);
    set_entry_only(8'd0, 1'b1);
    @(negedge clk);
    send_addr(a0, 1'b0, "R4");
    expect_result(a0, 1'b0, "R4 entry 0 cleared, rest set");
    @(negedge clk);
    set_entry_only(8'd0, 1'b0);
    rd_word(0, d);
    chk("R4 entry 0 is word 0 bit 31", d, 32'h80000000);
    send_addr(a0, 1'b0, "R4");
    expect_result(a0, 1'b1, "R4 entry 0 only");
    @(negedge clk);
    set_entry_only(8'd255, 1'b1);
    @(negedge clk);
    send_addr(a255, 1'b0, "R4");
    expect_result(a255, 1'b0, "R4 entry 255 cleared, rest set");
    @(negedge clk);
    set_entry_only(8'd255, 1'b0);
    rd_word(7, d);
    chk("R4 entry 255 is word 7 bit 0", d, 32'h00000001);
    send_addr(a255, 1'b0, "R4");
    expect_result(a255, 1'b1, "R4 entry 255 only");
    @(negedge clk);

    // R5: idle cycles between bytes
    set_entry_only(ref_idx(48'h01005E7FFFFA), 1'b0);
    @(negedge clk);
    send_addr(48'h01005E7FFFFA, 1'b1, "R5 gapped");
    expect_result(48'h01005E7FFFFA, 1'b1, "R5 gapped stream");
    @(negedge clk);
    chk("R5 gapped done single", 32'(lookup_done), 32'd0);

    // R8: back-to-back addresses
    fill_shadow(32'hFFFFFFFF);
    load_table();
    @(negedge clk);
    send_addr(48'h333300000001, 1'b0, "R8");
    expect_result(48'h333300000001, 1'b1, "R8 first");
    send_addr(48'h0180C2000000, 1'b0, "R8");
    expect_result(48'h0180C2000000, 1'b1, "R8 second");
    send_addr(48'h001122334455, 1'b0, "R8");
    expect_result(48'h001122334455, 1'b0, "R8 third unicast");
    @(negedge clk);

    finish_run();
  end
endmodule